// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt front end of a small 8-bit accumulator processor with a 16-bit address space. It watches two request pins. The urgent request counts only on a rising edge. That edge is caught in a latch and held until an entry services it. The ordinary request is a level, and it is honoured only while the block's mask flag is clear. The decision to take an interrupt is made one cycle before each instruction completes, on the core's sample strobe. The entry itself begins on the cycle after the core's end strobe.

An entry is a fixed seven-cycle microsequence. It has two internal cycles, then three writes into the stack page, then two vector reads. The writes push the return address high byte, then its low byte, then the status byte. The vector reads fetch the low byte and then the high byte of the new program counter. The mask flag is set once the status has been pushed. A one-byte break instruction, flagged by the core at its end strobe, runs the same sequence. For a break, the pushed return address skips one extra byte and the pushed status carries a break mark. The core stalls while `busy_o` is high and reloads its program counter from `pc_new_o` when `pc_load_o` pulses.

Top module: `irq_entry_seq`

## Requirements
- R1: A rising edge on `nmi_i` sets a pending latch, which stays set until an urgent entry starts. A pin held high causes only one entry, and a pin held high through reset causes none.
- R2: A high `irq_i` is taken at a sample point only while `mask_o` is 0. While `mask_o` is 1 it never starts an entry.
- R3: The take decision is formed on the clock edge where `insn_sample_i` is high. The entry starts on the edge where `insn_end_i` is high, and `busy_o` is then high for exactly 7 cycles. A request that appears only after the sample point waits for the next instruction.
- R4: When the urgent latch is set and the ordinary request is also valid at one sample point, the urgent entry is taken. The ordinary request stays outstanding.
- R5: An urgent entry reads its vector from 0xFFFA (low) and then 0xFFFB (high). An ordinary or break entry reads from 0xFFFE and then 0xFFFF. In the 7th cycle `pc_load_o` is 1 and `pc_new_o` is {high byte, low byte}.
- R6: Sequence cycles 1–2 are internal, with `addr_o` at 0 and `we_o` at 0. Cycles 3–5 are writes to address {0x01, sp}, and `sp_o` is decremented after each write. `we_o` is high only in those three cycles. `sp_o` resets to 0xFD.
- R7: The pushes are written in the order return high byte, return low byte, status. For a hardware entry, the return address is `next_pc_i` as seen at the end strobe.
- R8: `brk_i` with `insn_end_i` starts a break entry with return address `next_pc_i`+1. A break takes precedence at its own boundary, and a pending urgent request stays latched for the next boundary.
- R9: The pushed status is `status_i` with bit 4 replaced by 1 for a break and by 0 for a hardware entry. Bit 2 is replaced by the mask value held before the entry.
- R10: `mask_o` becomes 1 after the status push and is 1 when `pc_load_o` pulses. Outside a sequence, `mask_set_i` sets it and `mask_clr_i` clears it, and set wins if both are high.
- R11: Reset leaves no request pending, sets `mask_o` to 1, sets `sp_o` to 0xFD and leaves the block idle.
- R12: While `busy_o` is high, `insn_sample_i`, `insn_end_i`, `brk_i`, `mask_set_i` and `mask_clr_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_i | input | 1 | Urgent request, rising-edge sensitive |
| irq_i | input | 1 | Ordinary request, level sensitive |
| insn_sample_i | input | 1 | Core: the current instruction ends next cycle |
| insn_end_i | input | 1 | Core: last cycle of the current instruction |
| brk_i | input | 1 | Core: the ending instruction is the break opcode |
| mask_set_i | input | 1 | Core: set the mask flag |
| mask_clr_i | input | 1 | Core: clear the mask flag |
| next_pc_i | input | 16 | Address after the ending instruction |
| status_i | input | 8 | Core status byte (bits 2 and 4 replaced on push) |
| rdata_i | input | 8 | Memory read data, valid in the same cycle |
| addr_o | output | 16 | Memory address |
| wdata_o | output | 8 | Memory write data |
| we_o | output | 1 | Memory write strobe |
| busy_o | output | 1 | Entry sequence running; the core stalls |
| pc_load_o | output | 1 | New program counter valid |
| pc_new_o | output | 16 | Vector target |
| mask_o | output | 1 | Interrupt mask flag |
| sp_o | output | 8 | Stack pointer |

## Verification
The hardest situation to reach from the ports is an urgent request that is already latched when a break instruction completes. The break must win at that boundary, and the latch must survive the whole break entry and then win the next boundary. The stimulus pulses `nmi_i` a few cycles before issuing a break instruction, so the sample strobe sees the latch and the end strobe still carries `brk_i`. A second hard case is a request raised between the sample strobe and the end strobe. The stub raises `irq_i` on exactly the end cycle so that the deferral to the next instruction is visible.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_INT1,
      SQ_INT2,
      SQ_PUSH_HI,
      SQ_PUSH_LO,
      SQ_PUSH_ST,
      SQ_VEC_LO,
      SQ_VEC_HI
   } seq_state_e;

   typedef enum logic [1:0] {
      EK_IRQ,
      EK_NMI,
      EK_BRK
   } entry_kind_e;

   localparam int unsigned BRK_BIT  = 4;
   localparam int unsigned MASK_BIT = 2;

endpackage

// File: rtl/irqseq_nmi_latch.sv
module irqseq_nmi_latch #(
   parameter bit ACT_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_pin,
   input  logic clr,
   output logic pend
);

   logic lvl;
   logic lvl_q;
   logic rise;
   logic pend_q;

   generate
      if (ACT_LOW) begin : g_low
         assign lvl = ~nmi_pin;
      end else begin : g_high
         assign lvl = nmi_pin;
      end
   endgenerate

   assign rise = lvl & ~lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q  <= 1'b1;
         pend_q <= 1'b0;
      end else begin
         lvl_q  <= lvl;
         pend_q <= rise | (pend_q & ~clr);
      end
   end

   assign pend = pend_q;

   AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr) |=> pend_q); // R1

endmodule

// File: rtl/irqseq_arbiter.sv
module irqseq_arbiter
   import irqseq_pkg::*;
#(
   parameter bit IRQ_ACT_LOW = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        busy,
   input  logic        sample,
   input  logic        finish,
   input  logic        brk,
   input  logic        nmi_pend,
   input  logic        irq_pin,
   input  logic        mask,
   output logic        start,
   output entry_kind_e start_kind,
   output logic        nmi_clr
);

   logic irq_lvl;
   logic take_q;
   logic take_nmi_q;

   generate
      if (IRQ_ACT_LOW) begin : g_low
         assign irq_lvl = ~irq_pin;
      end else begin : g_high
         assign irq_lvl = irq_pin;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_q     <= 1'b0;
         take_nmi_q <= 1'b0;
      end else if (!busy) begin
         if (finish) begin
            take_q <= 1'b0;
         end else if (sample) begin
            take_q     <= nmi_pend | (irq_lvl & ~mask);
            take_nmi_q <= nmi_pend;
         end
      end
   end

   always_comb begin
      start      = !busy && finish && (brk || take_q);
      start_kind = brk ? EK_BRK : (take_nmi_q ? EK_NMI : EK_IRQ);
      nmi_clr    = start && !brk && take_nmi_q;
   end

   AST_CLR_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_clr |-> nmi_pend); // R1

endmodule

// File: rtl/irqseq_fsm.sv
module irqseq_fsm
   import irqseq_pkg::*;
#(
   parameter int unsigned            ADDR_W     = 16,
   parameter int unsigned            DATA_W     = 8,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
   parameter logic [DATA_W-1:0]      SP_RESET   = 'hFD,
   parameter logic [ADDR_W-1:0]      NMI_VEC    = 'hFFFA,
   parameter logic [ADDR_W-1:0]      IRQ_VEC    = 'hFFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  entry_kind_e       kind,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic              mask_in,
   input  logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              we,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_new,
   output logic              seq_mask_set,
   output logic [DATA_W-1:0] sp
);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] ret_q;
   logic [DATA_W-1:0] stat_q;
   logic [ADDR_W-1:0] vec_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] sp_q;
   logic [DATA_W-1:0] stat_build;

   always_comb begin
      stat_build           = status_in;
      stat_build[BRK_BIT]  = (kind == EK_BRK);
      stat_build[MASK_BIT] = mask_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         ret_q   <= '0;
         stat_q  <= '0;
         vec_q   <= '0;
         lo_q    <= '0;
         sp_q    <= SP_RESET;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  ret_q   <= (kind == EK_BRK) ? pc_in + 1'b1 : pc_in;
                  stat_q  <= stat_build;
                  vec_q   <= (kind == EK_NMI) ? NMI_VEC : IRQ_VEC;
                  state_q <= SQ_INT1;
               end
            end
            SQ_INT1:    state_q <= SQ_INT2;
            SQ_INT2:    state_q <= SQ_PUSH_HI;
            SQ_PUSH_HI: begin
               sp_q    <= sp_q - 1'b1;
               state_q <= SQ_PUSH_LO;
            end
            SQ_PUSH_LO: begin
               sp_q    <= sp_q - 1'b1;
               state_q <= SQ_PUSH_ST;
            end
            SQ_PUSH_ST: begin
               sp_q    <= sp_q - 1'b1;
               state_q <= SQ_VEC_LO;
            end
            SQ_VEC_LO: begin
               lo_q    <= rdata;
               state_q <= SQ_VEC_HI;
            end
            SQ_VEC_HI:  state_q <= SQ_IDLE;
            default:    state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      addr  = '0;
      wdata = '0;
      we    = 1'b0;
      unique case (state_q)
         SQ_PUSH_HI: begin
            addr  = {STACK_PAGE, sp_q};
            wdata = ret_q[ADDR_W-1:DATA_W];
            we    = 1'b1;
         end
         SQ_PUSH_LO: begin
            addr  = {STACK_PAGE, sp_q};
            wdata = ret_q[DATA_W-1:0];
            we    = 1'b1;
         end
         SQ_PUSH_ST: begin
            addr  = {STACK_PAGE, sp_q};
            wdata = stat_q;
            we    = 1'b1;
         end
         SQ_VEC_LO: addr = vec_q;
         SQ_VEC_HI: addr = vec_q + 1'b1;
         default: ;
      endcase
   end

   assign busy         = (state_q != SQ_IDLE);
   assign pc_load      = (state_q == SQ_VEC_HI);
   assign pc_new       = {rdata, lo_q};
   assign seq_mask_set = (state_q == SQ_PUSH_ST);
   assign sp           = sp_q;

   AST_SP_POSTDEC: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (sp_q == $past(sp_q) - 1'b1)); // R6

   AST_WE_IN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (addr[ADDR_W-1:DATA_W] == STACK_PAGE)); // R6

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irqseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter bit          NMI_ACT_LOW = 1'b0,
   parameter bit          IRQ_ACT_LOW = 1'b0,
   parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01,
   parameter logic [DATA_W-1:0]        SP_RESET   = 'hFD,
   parameter logic [ADDR_W-1:0]        NMI_VEC    = 'hFFFA,
   parameter logic [ADDR_W-1:0]        IRQ_VEC    = 'hFFFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_i,
   input  logic              irq_i,
   input  logic              insn_sample_i,
   input  logic              insn_end_i,
   input  logic              brk_i,
   input  logic              mask_set_i,
   input  logic              mask_clr_i,
   input  logic [ADDR_W-1:0] next_pc_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              we_o,
   output logic              busy_o,
   output logic              pc_load_o,
   output logic [ADDR_W-1:0] pc_new_o,
   output logic              mask_o,
   output logic [DATA_W-1:0] sp_o
);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("irq_entry_seq: ADDR_W must be twice DATA_W");
      end
      if (DATA_W <= BRK_BIT) begin : g_bad_status
         $error("irq_entry_seq: DATA_W too narrow for the break bit");
      end
   endgenerate

   logic        nmi_pend;
   logic        nmi_clr;
   logic        start;
   entry_kind_e start_kind;
   logic        busy;
   logic        seq_mask_set;
   logic        mask_q;

   irqseq_nmi_latch #(
      .ACT_LOW (NMI_ACT_LOW)
   ) i_nmi_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .nmi_pin (nmi_i),
      .clr     (nmi_clr),
      .pend    (nmi_pend)
   );

   irqseq_arbiter #(
      .IRQ_ACT_LOW (IRQ_ACT_LOW)
   ) i_arbiter (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .sample     (insn_sample_i),
      .finish     (insn_end_i),
      .brk        (brk_i),
      .nmi_pend   (nmi_pend),
      .irq_pin    (irq_i),
      .mask       (mask_q),
      .start      (start),
      .start_kind (start_kind),
      .nmi_clr    (nmi_clr)
   );

   irqseq_fsm #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .STACK_PAGE (STACK_PAGE),
      .SP_RESET   (SP_RESET),
      .NMI_VEC    (NMI_VEC),
      .IRQ_VEC    (IRQ_VEC)
   ) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .kind         (start_kind),
      .pc_in        (next_pc_i),
      .status_in    (status_i),
      .mask_in      (mask_q),
      .rdata        (rdata_i),
      .busy         (busy),
      .addr         (addr_o),
      .wdata        (wdata_o),
      .we           (we_o),
      .pc_load      (pc_load_o),
      .pc_new       (pc_new_o),
      .seq_mask_set (seq_mask_set),
      .sp           (sp_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (seq_mask_set) begin
         mask_q <= 1'b1;
      end else if (!busy) begin
         if (mask_set_i) begin
            mask_q <= 1'b1;
         end else if (mask_clr_i) begin
            mask_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy;
   assign mask_o = mask_q;

   AST_BUSY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(insn_end_i)); // R3

   AST_LOAD_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |=> !busy_o); // R3

   AST_MASK_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> mask_o); // R10

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_i = 1'b1;
   logic        irq_i = 1'b0;
   logic        insn_sample_i = 1'b0;
   logic        insn_end_i = 1'b0;
   logic        brk_i = 1'b0;
   logic        mask_set_i = 1'b0;
   logic        mask_clr_i = 1'b0;
   logic [15:0] next_pc_i = 16'h0200;
   logic [7:0]  status_i = 8'hE7;
   logic [7:0]  rdata_i;
   logic [15:0] addr_o;
   logic [7:0]  wdata_o;
   logic        we_o;
   logic        busy_o;
   logic        pc_load_o;
   logic [15:0] pc_new_o;
   logic        mask_o;
   logic [7:0]  sp_o;

   int n_cmp = 0;
   int n_bad = 0;
   int nmi_cnt = 0;
   int irq_cnt = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [7:0] mem_rd(input logic [15:0] a);
      case (a)
         16'hFFFA: return 8'h34;
         16'hFFFB: return 8'h12;
         16'hFFFE: return 8'hCD;
         16'hFFFF: return 8'hAB;
         default:  return a[7:0] ^ 8'h5A;
      endcase
   endfunction

   assign rdata_i = mem_rd(addr_o);

   irq_entry_seq i_irq_entry_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .nmi_i         (nmi_i),
      .irq_i         (irq_i),
      .insn_sample_i (insn_sample_i),
      .insn_end_i    (insn_end_i),
      .brk_i         (brk_i),
      .mask_set_i    (mask_set_i),
      .mask_clr_i    (mask_clr_i),
      .next_pc_i     (next_pc_i),
      .status_i      (status_i),
      .rdata_i       (rdata_i),
      .addr_o        (addr_o),
      .wdata_o       (wdata_o),
      .we_o          (we_o),
      .busy_o        (busy_o),
      .pc_load_o     (pc_load_o),
      .pc_new_o      (pc_new_o),
      .mask_o        (mask_o),
      .sp_o          (sp_o)
   );

   task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int          m_step = 0;
   bit          m_pend, m_take, m_tnmi, m_mask, m_prev, m_brk;
   logic [7:0]  m_sp;
   logic [15:0] m_vec;
   logic [7:0]  m_push[$];

   always @(posedge clk) begin
      bit rise, old_pend, old_mask, go_nmi;
      logic [15:0] r;
      logic [7:0]  st;
      if (!rst_n) begin
         m_step = 0; m_pend = 0; m_take = 0; m_tnmi = 0; m_mask = 1;
         m_prev = 1; m_sp = 8'hFD; m_brk = 0; m_push.delete();
      end else begin
         rise = nmi_i && !m_prev;
         m_prev = nmi_i;
         old_pend = m_pend;
         old_mask = m_mask;
         go_nmi = 0;
         if (m_step == 0) begin
            if (insn_end_i) begin
               if (brk_i || m_take) begin
                  m_brk = brk_i;
                  r  = brk_i ? next_pc_i + 16'd1 : next_pc_i;
                  st = (status_i & 8'hEB) | (brk_i ? 8'h10 : 8'h00) | (old_mask ? 8'h04 : 8'h00);
                  m_push.delete();
                  m_push.push_back(r[15:8]);
                  m_push.push_back(r[7:0]);
                  m_push.push_back(st);
                  go_nmi = !brk_i && m_tnmi;
                  m_vec  = go_nmi ? 16'hFFFA : 16'hFFFE;
                  m_step = 1;
               end
               m_take = 0;
            end else if (insn_sample_i) begin
               m_take = old_pend || (irq_i && !old_mask);
               m_tnmi = old_pend;
            end
            if (mask_set_i) m_mask = 1;
            else if (mask_clr_i) m_mask = 0;
         end else begin
            if (m_step >= 3 && m_step <= 5) begin
               void'(m_push.pop_front());
               m_sp = m_sp - 8'd1;
            end
            if (m_step == 5) m_mask = 1;
            m_step = (m_step == 7) ? 0 : m_step + 1;
         end
         if (go_nmi) m_pend = 0;
         if (rise) m_pend = 1;
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cmp("R3 busy", {15'd0, busy_o}, {15'd0, m_step != 0});
         cmp("R6 write strobe", {15'd0, we_o}, {15'd0, m_step >= 3 && m_step <= 5});
         cmp("R6 stack pointer", {8'd0, sp_o}, {8'd0, m_sp});
         cmp("R10 mask", {15'd0, mask_o}, {15'd0, m_mask});
         if (m_step >= 3 && m_step <= 5) begin
            cmp("R6 push address", addr_o, {8'h01, m_sp});
            cmp(m_brk ? "R7 R8 R9 break push data" : "R7 R9 push data",
                {8'd0, wdata_o}, {8'd0, m_push[0]});
         end else if (m_step == 6) begin
            cmp("R5 vector low address", addr_o, m_vec);
         end else if (m_step == 7) begin
            cmp("R5 vector high address", addr_o, m_vec + 16'd1);
         end else begin
            cmp("R6 idle address", addr_o, 16'h0000);
         end
         cmp("R5 load strobe", {15'd0, pc_load_o}, {15'd0, m_step == 7});
         if (m_step == 7)
            cmp("R5 new pc", pc_new_o, {mem_rd(m_vec + 16'd1), mem_rd(m_vec)});
         if (pc_load_o) begin
            if (pc_new_o == 16'h1234) nmi_cnt++;
            else if (pc_new_o == 16'hABCD) irq_cnt++;
         end
      end
   end

   // ---------------- core stub ----------------
   task automatic step(input bit s, input bit e, input bit b);
      @(negedge clk);
      while (busy_o) begin
         insn_sample_i = 0; insn_end_i = 0; brk_i = 0;
         mask_set_i = 0; mask_clr_i = 0;
         @(negedge clk);
      end
      insn_sample_i = s; insn_end_i = e; brk_i = b;
      mask_set_i = 0; mask_clr_i = 0;
   endtask

   task automatic insn(input int len, input bit b, input logic [15:0] nxt);
      next_pc_i = nxt;
      for (int c = 1; c <= len; c++) step(c == len - 1, c == len, b && (c == len));
      step(0, 0, 0);
   endtask

   task automatic set_mask(input bit s, input bit c);
      step(0, 0, 0);
      mask_set_i = s; mask_clr_i = c;
      step(0, 0, 0);
   endtask

   task automatic nmi_pulse();
      @(negedge clk); nmi_i = 1;
      @(negedge clk); nmi_i = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;                                    // nmi_i held high through reset
      repeat (3) @(negedge clk);
      cmp("R11 reset mask", {15'd0, mask_o}, 16'd1);
      cmp("R11 reset sp", {8'd0, sp_o}, 16'h00FD);
      cmp("R11 reset idle", {15'd0, busy_o}, 16'd0);
      insn(3, 0, 16'h0203);
      insn(2, 0, 16'h0205);
      nmi_i = 0;
      cmp("R11 no entry from level held through reset", nmi_cnt[15:0], 16'd0);

      // R2: ordinary request while masked
      irq_i = 1;
      insn(3, 0, 16'h0208);
      insn(4, 0, 16'h020C);
      cmp("R2 masked request ignored", irq_cnt[15:0], 16'd0);
      set_mask(0, 1);
      insn(3, 0, 16'h0210);
      cmp("R2 R7 ordinary entry taken", irq_cnt[15:0], 16'd1);
      insn(3, 0, 16'hABD0);
      insn(2, 0, 16'hABD2);
      cmp("R10 handler masked, no re-entry", irq_cnt[15:0], 16'd1);
      irq_i = 0;

      // R10: set wins over clear
      set_mask(1, 1);
      cmp("R10 set wins", {15'd0, mask_o}, 16'd1);

      // R1: urgent edge while masked, then held high
      @(negedge clk); nmi_i = 1;
      insn(4, 0, 16'h0300);
      cmp("R1 urgent entry while masked", nmi_cnt[15:0], 16'd1);
      insn(3, 0, 16'h1236);
      insn(3, 0, 16'h1239);
      insn(2, 0, 16'h123B);
      cmp("R1 held level gives one entry", nmi_cnt[15:0], 16'd1);
      nmi_i = 0;

      // R4: both at one sample point
      set_mask(0, 1);
      irq_i = 1;
      nmi_pulse();
      insn(3, 0, 16'h0400);
      cmp("R4 urgent wins", nmi_cnt[15:0], 16'd2);
      cmp("R4 ordinary waits", irq_cnt[15:0], 16'd1);
      set_mask(0, 1);
      insn(2, 0, 16'h1236);
      cmp("R4 ordinary taken later", irq_cnt[15:0], 16'd2);
      irq_i = 0;

      // R3: request raised after the sample point
      set_mask(0, 1);
      step(1, 0, 0);
      step(0, 1, 0); irq_i = 1;
      step(0, 0, 0); irq_i = 0;
      step(0, 0, 0);
      cmp("R3 late request deferred", irq_cnt[15:0], 16'd2);

      // R8 R9: break with mask clear
      insn(2, 1, 16'h0501);
      cmp("R8 break entry", irq_cnt[15:0], 16'd3);

      // R8: break while urgent pending
      nmi_pulse();
      insn(2, 1, 16'h0601);
      cmp("R8 break precedence", irq_cnt[15:0], 16'd4);
      cmp("R8 urgent still pending", nmi_cnt[15:0], 16'd2);
      insn(2, 0, 16'hABD0);
      cmp("R8 urgent taken next", nmi_cnt[15:0], 16'd3);

      // R12: strobes during a sequence
      step(1, 0, 0);
      step(0, 1, 1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         insn_sample_i = 1; insn_end_i = 1; brk_i = 1; mask_clr_i = 1;
      end
      @(negedge clk);
      insn_sample_i = 0; insn_end_i = 0; brk_i = 0; mask_clr_i = 0;
      repeat (6) @(negedge clk);
      cmp("R12 one entry only", irq_cnt[15:0], 16'd5);
      cmp("R12 mask unchanged", {15'd0, mask_o}, 16'd1);
      cmp("R12 idle after", {15'd0, busy_o}, 16'd0);

      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule